// File: doc/BRIEF.md
# Debounced Pin-Change Interrupt with Key-Press Reset Request

This block is the input side of one interrupt-capable pin group. Each pin is first brought into the core clock domain by a two-stage synchronizer. A per-pin enable can then route it through a debounce filter. The filter accepts a new level only after that level has been seen on four consecutive sampling ticks. The tick is taken from one of four source tick inputs and divided by a power of two. The resulting per-pin level is edge-detected, and a per-pin polarity bit picks the edge of interest.

A detected edge sets a sticky per-pin flag. The flags are ANDed with per-pin interrupt enables and ORed into a single interrupt line. A separate detector watches the lowest pins. When every pin in a configurable set is low at the same time, it raises a reset request level.

Software reaches the configuration, the flags and the current filtered levels through a small register port. Writes are synchronous and reads are combinational.

Top module: `port_irq_keyrst`

## Requirements
- R1: After reset, every configuration register reads 0, all flags read 0, `irq` is low and `key_rst_req` is low.
- R2: With the filter bypassed (bit clear at address 0), a pin transition sets its flag three rising clock edges after the pin changes. The current per-pin levels after the filter/bypass choice read back at address 6.
- R3: The per-pin bit at address 1 selects the edge: 0 flags a rising (low-to-high) level and 1 flags a falling level. The other transition sets no flag.
- R4: A flag is set whatever its interrupt enable (address 2). `irq` is high exactly when some pin has both its flag and its enable set, and it follows an enable write in the same cycle that the register updates.
- R5: Flags (address 3) stay set until software writes 1 to that bit at address 3. Writing 0, or writing 1 to another bit, leaves the flag unchanged.
- R6: With the filter enabled, the filtered level changes only after the synchronized input holds the new level for four consecutive ticks. A pulse lasting three ticks is rejected. With one tick per clock, a flag appears seven rising edges after the pin changes.
- R7: The divider field, bits [5:2] at address 4, set to n gives one sampling tick every 2^n pulses of the selected source.
- R8: The source field, bits [1:0] at address 4, selects which of the four `src_tick` inputs drives the filter. A source that never pulses freezes every filtered level.
- R9: The key field at address 5 selects the pins watched for the key reset: 0 turns the request off, 1 watches pins 0 and 1, 2 watches pins 0 to 2, and 3 watches pins 0 to 3.
- R10: `key_rst_req` is a registered level. It rises and falls three rising edges after the last watched pin goes low or the first one is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Raw pin levels |
| src_tick | input | 4 | Source tick pulses, one per selectable sampling source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from the address |
| irq | output | 1 | Group interrupt |
| key_rst_req | output | 1 | Key-press reset request level |

## Verification
A pin change takes three rising edges to reach a flag or the key request when bypassed. It takes seven when the filter sees a tick on every clock. A register write takes effect at the edge that accepts it. The bench drives pins and writes on falling edges and counts falling edges after the stimulus. For each case it checks once on the falling edge just before the result is due, and once on the falling edge where it must have arrived. In divided-tick cases the tick phase is unknown, so the bench checks the result at a bound that covers the worst phase. It also checks a short window where a pass-through would already show.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;

    localparam int SRC_SEL_W = 2;
    localparam int SRC_N     = 1 << SRC_SEL_W;
    localparam int DIV_W     = 4;
    localparam int DEB_HOLD  = 4;
    localparam int KEY_W     = 4;

    typedef enum logic [2:0] {
        RA_FILT_EN  = 3'd0,
        RA_EDGE_SEL = 3'd1,
        RA_IRQ_EN   = 3'd2,
        RA_FLAGS    = 3'd3,
        RA_CLK_CTL  = 3'd4,
        RA_KEY_CFG  = 3'd5,
        RA_LEVEL    = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [DIV_W-1:0]     div;
        logic [SRC_SEL_W-1:0] src;
    } clk_ctl_t;

    function automatic logic [KEY_W-1:0] key_mask(input logic [1:0] cfg);
        case (cfg)
            2'd1:    return 4'b0011;
            2'd2:    return 4'b0111;
            2'd3:    return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/pirq_tick_gen.sv
`timescale 1ns/1ps
module pirq_tick_gen
    import pirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_N-1:0]     src_tick,
    input  logic [SRC_SEL_W-1:0] sel,
    input  logic [DIV_W-1:0]     div,
    output logic                 tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;
    logic             src_on;

    assign src_on = src_tick[sel];
    assign mask   = (CNT_W'(1) << div) - CNT_W'(1);
    assign tick   = src_on && ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (src_on)
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/pirq_debounce.sv
`timescale 1ns/1ps
module pirq_debounce #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic din,
    output logic dout
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= 1'b0;
            run_q <= '0;
        end else if (tick) begin
            if (din != dout) begin
                if (run_q == CW'(HOLD - 1)) begin
                    dout  <= din;
                    run_q <= '0;
                end else begin
                    run_q <= run_q + CW'(1);
                end
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/pirq_flag_bank.sv
`timescale 1ns/1ps
module pirq_flag_bank #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] level,
    input  logic [NPINS-1:0] edge_sel,
    input  logic [NPINS-1:0] irq_en,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] flags,
    output logic             irq
);
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] hit;

    for (genvar i = 0; i < NPINS; i++) begin : g_edge
        assign hit[i] = edge_sel[i] ? (prev_q[i] & ~level[i])
                                    : (~prev_q[i] & level[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            flags  <= '0;
        end else begin
            prev_q <= level;
            flags  <= (flags & ~clr) | hit;
        end
    end

    assign irq = |(flags & irq_en);
endmodule

// File: rtl/port_irq_keyrst.sv
`timescale 1ns/1ps
module port_irq_keyrst
    import pirq_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    input  logic [SRC_N-1:0] src_tick,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq,
    output logic             key_rst_req
);
    localparam int CTL_W = $bits(clk_ctl_t);

    logic [NPINS-1:0] filt_en, edge_sel, irq_en;
    clk_ctl_t         clk_ctl;
    logic [1:0]       key_cfg;
    logic [NPINS-1:0] sync1_q, sync2_q;
    logic [NPINS-1:0] deb_q, level, flags, clr;
    logic             tick;
    reg_addr_e        addr;

    assign addr = reg_addr_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_en  <= '0;
            edge_sel <= '0;
            irq_en   <= '0;
            clk_ctl  <= '0;
            key_cfg  <= '0;
        end else if (reg_wr) begin
            case (addr)
                RA_FILT_EN:  filt_en  <= reg_wdata[NPINS-1:0];
                RA_EDGE_SEL: edge_sel <= reg_wdata[NPINS-1:0];
                RA_IRQ_EN:   irq_en   <= reg_wdata[NPINS-1:0];
                RA_CLK_CTL:  clk_ctl  <= clk_ctl_t'(reg_wdata[CTL_W-1:0]);
                RA_KEY_CFG:  key_cfg  <= reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    assign clr = (reg_wr && addr == RA_FLAGS) ? reg_wdata[NPINS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
        end
    end

    pirq_tick_gen u_tick (
        .clk      (clk),
        .rst      (rst),
        .src_tick (src_tick),
        .sel      (clk_ctl.src),
        .div      (clk_ctl.div),
        .tick     (tick)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pirq_debounce #(.HOLD(DEB_HOLD)) u_deb (
            .clk  (clk),
            .rst  (rst),
            .tick (tick),
            .din  (sync2_q[i]),
            .dout (deb_q[i])
        );
        assign level[i] = filt_en[i] ? deb_q[i] : sync2_q[i];
    end

    pirq_flag_bank #(.NPINS(NPINS)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .level    (level),
        .edge_sel (edge_sel),
        .irq_en   (irq_en),
        .clr      (clr),
        .flags    (flags),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)
            key_rst_req <= 1'b0;
        else
            key_rst_req <= (key_cfg != 2'd0) &&
                           ((level[KEY_W-1:0] & key_mask(key_cfg)) == '0);
    end

    always_comb begin
        case (addr)
            RA_FILT_EN:  reg_rdata = DW'(filt_en);
            RA_EDGE_SEL: reg_rdata = DW'(edge_sel);
            RA_IRQ_EN:   reg_rdata = DW'(irq_en);
            RA_FLAGS:    reg_rdata = DW'(flags);
            RA_CLK_CTL:  reg_rdata = DW'(clk_ctl);
            RA_KEY_CFG:  reg_rdata = DW'(key_cfg);
            RA_LEVEL:    reg_rdata = DW'(level);
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/port_irq_keyrst_chk.sv
`timescale 1ns/1ps
module port_irq_keyrst_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             key_rst_req,
    input logic [NPINS-1:0] irq_en,
    input logic [NPINS-1:0] flags,
    input logic [NPINS-1:0] clr,
    input logic [NPINS-1:0] deb_q,
    input logic             tick,
    input logic [1:0]       key_cfg,
    input logic [3:0]       key_level
);
    // R4: with every enable clear the group line stays low
    a_r4_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq);

    // R5: without a clear strobe no flag drops
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (clr == '0) |=> (($past(flags) & ~flags) == '0));

    // R6: debounced levels move only on a sampling tick
    a_r6_filter_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(deb_q));

    // R9: key request off when the field is 0
    a_r9_key_disabled: assert property (@(posedge clk) disable iff (rst)
        (key_cfg == 2'd0) |=> !key_rst_req);

    // R10: all four watched pins low gives a request next cycle
    a_r10_key_all_low: assert property (@(posedge clk) disable iff (rst)
        (key_cfg == 2'd3 && key_level == 4'b0000) |=> key_rst_req);
endmodule

bind port_irq_keyrst port_irq_keyrst_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq         (irq),
    .key_rst_req (key_rst_req),
    .irq_en      (irq_en),
    .flags       (flags),
    .clr         (clr),
    .deb_q       (deb_q),
    .tick        (tick),
    .key_cfg     (key_cfg),
    .key_level   (level[3:0])
);

// File: tb/port_irq_keyrst_tb.sv
`timescale 1ns/1ps
module port_irq_keyrst_tb;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_in = '1;
    logic          src1 = 1'b0;
    logic [3:0]    src_tick;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          irq, key_rst_req;

    int n_chk = 0;
    int n_fail = 0;

    assign src_tick = {2'b00, src1, 1'b1};

    always #10 clk = ~clk;
    always @(negedge clk) src1 <= ~src1;

    port_irq_keyrst #(.NPINS(NP), .DW(8)) u_dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .src_tick(src_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .key_rst_req(key_rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_flags(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        rd(3'd3, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 config/flags", v, 8'h00);
        end
        chk("R1 irq", irq, 1'b0);
        chk("R1 key_rst_req", key_rst_req, 1'b0);
        waitn(6);
        wr(3'd3, 8'hFF);
        chk_flags("R5 clear all", 8'h00);
    endtask

    task automatic t_bypass;
        logic [7:0] v;
        pin_in[0] = 1'b0;
        waitn(5);
        chk_flags("R3 falling ignored on rising select", 8'h00);
        rd(3'd6, v);
        chk("R2 level readback", v, 8'hFE);
        pin_in[0] = 1'b1;
        waitn(2);
        chk_flags("R2 not before third edge", 8'h00);
        waitn(1);
        chk_flags("R2 rising flag at third edge", 8'h01);
        wr(3'd3, 8'h01);
        wr(3'd1, 8'h02);
        pin_in[1] = 1'b0;
        waitn(2);
        chk_flags("R3 falling not yet", 8'h00);
        waitn(1);
        chk_flags("R3 falling select flags", 8'h02);
    endtask

    task automatic t_mask;
        chk("R4 flag set, enable clear", irq, 1'b0);
        wr(3'd2, 8'h01);
        chk("R4 other pin enabled", irq, 1'b0);
        wr(3'd2, 8'h02);
        chk("R4 matching enable", irq, 1'b1);
        wr(3'd2, 8'h00);
        chk("R4 enable removed", irq, 1'b0);
    endtask

    task automatic t_sticky;
        wr(3'd3, 8'h00);
        chk_flags("R5 write 0 no effect", 8'h02);
        wr(3'd3, 8'h01);
        chk_flags("R5 other bit no effect", 8'h02);
        wr(3'd3, 8'h02);
        chk_flags("R5 write 1 clears", 8'h00);
        pin_in[1] = 1'b1;
        waitn(5);
        chk_flags("R3 rising ignored on falling select", 8'h00);
    endtask

    task automatic t_filter;
        wr(3'd0, 8'h04);
        waitn(12);
        wr(3'd1, 8'h04);
        wr(3'd3, 8'hFF);
        pin_in[2] = 1'b0;
        waitn(3);
        pin_in[2] = 1'b1;
        waitn(10);
        chk_flags("R6 three-tick glitch rejected", 8'h00);
        pin_in[2] = 1'b0;
        waitn(6);
        chk_flags("R6 not before seventh edge", 8'h00);
        waitn(1);
        chk_flags("R6 flag at seventh edge", 8'h04);
        wr(3'd3, 8'h04);
        pin_in[2] = 1'b1;
        waitn(10);
    endtask

    task automatic t_div;
        wr(3'd4, 8'h0C);
        pin_in[2] = 1'b0;
        waitn(20);
        pin_in[2] = 1'b1;
        waitn(40);
        chk_flags("R7 20-cycle pulse rejected at div 3", 8'h00);
        pin_in[2] = 1'b0;
        waitn(7);
        chk_flags("R7 divided tick slower than clock", 8'h00);
        waitn(38);
        chk_flags("R7 accepted after four divided ticks", 8'h04);
        wr(3'd3, 8'h04);
        pin_in[2] = 1'b1;
        waitn(45);
    endtask

    task automatic t_src;
        logic [7:0] v;
        wr(3'd4, 8'h02);
        pin_in[2] = 1'b0;
        waitn(40);
        chk_flags("R8 idle source freezes filter", 8'h00);
        rd(3'd6, v);
        chk("R8 filtered level held", v, 8'hFF);
        wr(3'd4, 8'h01);
        waitn(12);
        chk_flags("R8 pulsing source resumes filter", 8'h04);
        pin_in[2] = 1'b1;
        waitn(12);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h00);
        waitn(5);
        wr(3'd3, 8'hFF);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_key;
        pin_in[3:0] = 4'b0000;
        waitn(5);
        chk("R9 field 0 disables", key_rst_req, 1'b0);
        wr(3'd5, 8'h01);
        waitn(1);
        chk("R9 pins 0-1 low", key_rst_req, 1'b1);
        pin_in[3:2] = 2'b11;
        waitn(3);
        chk("R9 pins 2-3 not watched at 1", key_rst_req, 1'b1);
        pin_in[1] = 1'b1;
        waitn(2);
        chk("R10 still held before third edge", key_rst_req, 1'b1);
        waitn(1);
        chk("R10 drops at third edge", key_rst_req, 1'b0);
        wr(3'd5, 8'h02);
        pin_in[1] = 1'b0;
        waitn(3);
        chk("R9 pin 2 high blocks at 2", key_rst_req, 1'b0);
        pin_in[2] = 1'b0;
        waitn(2);
        chk("R10 not before third edge", key_rst_req, 1'b0);
        waitn(1);
        chk("R10 rises at third edge", key_rst_req, 1'b1);
        wr(3'd5, 8'h03);
        waitn(1);
        chk("R9 pin 3 high blocks at 3", key_rst_req, 1'b0);
        pin_in[3] = 1'b0;
        waitn(3);
        chk("R9 pins 0-3 low at 3", key_rst_req, 1'b1);
        pin_in[3:0] = 4'hF;
        waitn(3);
        chk("R10 released", key_rst_req, 1'b0);
        wr(3'd5, 8'h00);
    endtask

    initial begin
        waitn(5);
        rst = 1'b0;
        t_reset();
        t_bypass();
        t_mask();
        t_sticky();
        t_filter();
        t_div();
        t_src();
        t_key();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule